// File: doc/BRIEF.md
# Streaming Turning-Point Waveform Compressor

This block sits directly behind a 12-bit sample source and shrinks each acquired record while it is still arriving. In compressed mode it follows the trend of the signal and emits only the turning points: the peak reached before the signal falls back by more than a programmable hysteresis, and the trough reached before it climbs back by more than that hysteresis. Each point carries its sample position in the record and a flag that marks it as a maximum or a minimum. In full mode every sample inside a record is passed on unchanged, with its position.

Records are framed by start and end markers on the sample stream. A sample is accepted on every clock, and there is no backpressure on the input. The output is a valid/ready stream buffered by a small FIFO. If that FIFO fills, new points are dropped and a sticky error flag is raised, which stays set until reset. Mode and hysteresis are expected to stay constant for the whole of a record.

Top module: `wave_turnpt_top`

## Requirements
- R1: After reset, out_valid and out_overflow are 0.
- R2: In full mode (mode_full=1), every accepted sample of a record is emitted in arrival order. The index counts from 0 at the start-marked sample, and out_is_max is 0.
- R3: A valid sample outside a record is ignored. This covers samples before the first start marker and samples after an end marker, until the next start marker.
- R4: In compressed mode (mode_full=0), a maximum (out_is_max=1) is emitted when a sample falls below the running peak by strictly more than hyst. The record reports the peak's value and index, and tracking then continues downward from that sample.
- R5: Minima are handled the same way with the direction reversed. A minimum (out_is_max=0) is emitted when a sample rises above the running trough by strictly more than hyst.
- R6: A sample equal to the running extreme does not replace it, so the first index at which the extreme value occurred is reported.
- R7: At the start of a record no trend exists. Nothing is emitted until a sample differs from the first sample of the record by strictly more than hyst, and that sample's direction sets the first trend.
- R8: The end-marked sample may only extend the running extreme. After that, the pending extreme is emitted as the final point. If no trend exists yet, nothing is emitted.
- R9: While out_valid is 1 and out_ready is 0, the output record is held unchanged.
- R10: The output FIFO holds FIFO_DEPTH records. A point produced while the FIFO is full is dropped and sets out_overflow, which stays 1 until reset.
- R11: One sample per clock is accepted with no gaps required. The tracker presents a point one cycle after the sample that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_full | input | 1 | 1: pass all samples, 0: turning points only |
| hyst | input | 12 | Hysteresis threshold for a trend reversal |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | 12 | Unsigned sample value |
| in_sor | input | 1 | Sample is the first of a record |
| in_eor | input | 1 | Sample is the last of a record |
| out_valid | output | 1 | Output record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_index | output | 16 | Sample index within the record |
| out_value | output | 12 | Sample value |
| out_is_max | output | 1 | 1: maximum, 0: minimum or full-mode sample |
| out_overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench goes after the exact hysteresis boundary. A drop equal to hyst must not reverse the trend, so a design that compared with greater-or-equal would emit an early, wrong peak. Repeated equal peaks are included, because a design that updated on equality would report a later index. End-of-record handling is tested both with a trend in place and with none: a missing flush loses the last point, and a careless flush emits a spurious one. Backpressure and overflow are checked by stalling the consumer: a design that let the held record change, or cleared the error flag on drain, would be caught. Random walks with several hysteresis values are compared against a bench model of the rules above.

// File: rtl/wave_turnpt_pkg.sv
package wave_turnpt_pkg;
    parameter int DATA_W = 12;
    parameter int IDX_W  = 16;

    typedef enum logic [1:0] {
        TREND_NONE = 2'd0,
        TREND_UP   = 2'd1,
        TREND_DOWN = 2'd2
    } trend_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
        logic              is_max;
    } point_t;

    localparam int POINT_W = $bits(point_t);

    // true when a exceeds b by strictly more than h
    function automatic logic beyond(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b,
                                    input logic [DATA_W-1:0] h);
        logic [DATA_W:0] df;
        df = {1'b0, a} - {1'b0, b};
        return !df[DATA_W] && (df[DATA_W-1:0] > h);
    endfunction
endpackage

// File: rtl/wave_turnpt_tracker.sv
module wave_turnpt_tracker
    import wave_turnpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_full,
    input  logic [DATA_W-1:0] hyst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sor,
    input  logic              in_eor,
    output logic              emit,
    output point_t            point
);
    typedef struct packed {
        logic              active;
        trend_e            trend;
        logic [DATA_W-1:0] ext_val;
        logic [IDX_W-1:0]  ext_idx;
        logic [DATA_W-1:0] first_val;
        logic [IDX_W-1:0]  idx;
        logic              emit;
        point_t            pt;
    } trk_t;

    trk_t q, d;

    logic              take;
    logic              up_from_first, down_from_first;
    logic              above_ext, below_ext, drop_ext, rise_ext;
    trend_e            trend_v;
    logic [DATA_W-1:0] ext_v;
    logic [IDX_W-1:0]  ext_idx_v;
    logic [IDX_W-1:0]  idx_v;

    assign take            = in_valid && (in_sor || q.active);
    assign up_from_first   = beyond(in_data, q.first_val, hyst);
    assign down_from_first = beyond(q.first_val, in_data, hyst);
    assign above_ext       = in_data > q.ext_val;
    assign below_ext       = in_data < q.ext_val;
    assign drop_ext        = beyond(q.ext_val, in_data, hyst);
    assign rise_ext        = beyond(in_data, q.ext_val, hyst);

    always_comb begin
        d         = q;
        d.emit    = 1'b0;
        trend_v   = q.trend;
        ext_v     = q.ext_val;
        ext_idx_v = q.ext_idx;
        idx_v     = q.idx;
        if (take) begin
            if (in_sor) begin
                idx_v       = '0;
                trend_v     = TREND_NONE;
                ext_v       = in_data;
                ext_idx_v   = '0;
                d.first_val = in_data;
            end
            d.idx    = idx_v + 1'b1;
            d.active = !in_eor;
            if (mode_full) begin
                d.emit = 1'b1;
                d.pt   = '{idx: idx_v, val: in_data, is_max: 1'b0};
            end else if (in_eor) begin
                // final sample may only extend the pending extreme
                if (trend_v == TREND_UP) begin
                    if (above_ext && !in_sor) begin
                        ext_v     = in_data;
                        ext_idx_v = idx_v;
                    end
                    d.emit = 1'b1;
                    d.pt   = '{idx: ext_idx_v, val: ext_v, is_max: 1'b1};
                end else if (trend_v == TREND_DOWN) begin
                    if (below_ext && !in_sor) begin
                        ext_v     = in_data;
                        ext_idx_v = idx_v;
                    end
                    d.emit = 1'b1;
                    d.pt   = '{idx: ext_idx_v, val: ext_v, is_max: 1'b0};
                end
            end else if (!in_sor) begin
                case (trend_v)
                    TREND_NONE: begin
                        if (up_from_first) begin
                            trend_v   = TREND_UP;
                            ext_v     = in_data;
                            ext_idx_v = idx_v;
                        end else if (down_from_first) begin
                            trend_v   = TREND_DOWN;
                            ext_v     = in_data;
                            ext_idx_v = idx_v;
                        end
                    end
                    TREND_UP: begin
                        if (above_ext) begin
                            ext_v     = in_data;
                            ext_idx_v = idx_v;
                        end else if (drop_ext) begin
                            d.emit    = 1'b1;
                            d.pt      = '{idx: q.ext_idx, val: q.ext_val, is_max: 1'b1};
                            trend_v   = TREND_DOWN;
                            ext_v     = in_data;
                            ext_idx_v = idx_v;
                        end
                    end
                    TREND_DOWN: begin
                        if (below_ext) begin
                            ext_v     = in_data;
                            ext_idx_v = idx_v;
                        end else if (rise_ext) begin
                            d.emit    = 1'b1;
                            d.pt      = '{idx: q.ext_idx, val: q.ext_val, is_max: 1'b0};
                            trend_v   = TREND_UP;
                            ext_v     = in_data;
                            ext_idx_v = idx_v;
                        end
                    end
                    default: trend_v = TREND_NONE;
                endcase
            end
            d.trend   = trend_v;
            d.ext_val = ext_v;
            d.ext_idx = ext_idx_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign emit  = q.emit;
    assign point = q.pt;

    // R2: a full-mode sample inside a record appears one cycle later, unchanged
    a_r2_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_full && (in_sor || q.active))
        |=> (q.emit && q.pt.val == $past(in_data) && !q.pt.is_max));

    // R2: the start-marked sample carries index 0
    a_r2_sor_index: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sor && mode_full) |=> (q.pt.idx == '0));

    // R3: a stray sample outside a record produces nothing
    a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sor && !q.active) |=> !q.emit);

    // R11: a point is produced only from a sample of the previous cycle
    a_r11_emit_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !q.emit);
endmodule

// File: rtl/wave_turnpt_fifo.sv
module wave_turnpt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         ovf
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W:0]   count;
        logic             ovf;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic rd_ok, wr_ok;

    assign rd_ok = rd_en && (q.count != '0);
    assign wr_ok = wr_en && ((q.count != (PTR_W+1)'(DEPTH)) || rd_ok);

    always_comb begin
        d = q;
        if (rd_ok) d.rd_ptr = q.rd_ptr + 1'b1;
        if (wr_ok) d.wr_ptr = q.wr_ptr + 1'b1;
        case ({wr_ok, rd_ok})
            2'b10:   d.count = q.count + 1'b1;
            2'b01:   d.count = q.count - 1'b1;
            default: d.count = q.count;
        endcase
        if (wr_en && !wr_ok) d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[q.wr_ptr] <= wr_data;
    end

    assign rd_data = mem[q.rd_ptr];
    assign empty   = (q.count == '0);
    assign ovf     = q.ovf;

    // R10: a write into a full, unread FIFO leaves it full and flags overflow
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (q.count == (PTR_W+1)'(DEPTH) && wr_en && !rd_en)
        |=> (q.count == (PTR_W+1)'(DEPTH) && q.ovf));
endmodule

// File: rtl/wave_turnpt_top.sv
module wave_turnpt_top
    import wave_turnpt_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_full,
    input  logic [DATA_W-1:0] hyst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sor,
    input  logic              in_eor,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_index,
    output logic [DATA_W-1:0] out_value,
    output logic              out_is_max,
    output logic              out_overflow
);
    logic   emit;
    point_t pt_w, pt_r;
    logic   fifo_empty;

    wave_turnpt_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_full (mode_full),
        .hyst      (hyst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sor    (in_sor),
        .in_eor    (in_eor),
        .emit      (emit),
        .point     (pt_w)
    );

    wave_turnpt_fifo #(.DEPTH(FIFO_DEPTH), .W(POINT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (emit),
        .wr_data (pt_w),
        .rd_en   (out_valid && out_ready),
        .rd_data (pt_r),
        .empty   (fifo_empty),
        .ovf     (out_overflow)
    );

    assign out_valid  = !fifo_empty;
    assign out_index  = pt_r.idx;
    assign out_value  = pt_r.val;
    assign out_is_max = pt_r.is_max;

    // R9: a stalled record stays put
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && $stable({out_index, out_value, out_is_max})));

    // R10: the overflow flag never clears on its own
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |=> out_overflow);
endmodule

// File: tb/tb_wave_turnpt_top.sv
module tb_wave_turnpt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_full = 1'b0;
    logic [11:0] hyst = '0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_sor = 1'b0;
    logic        in_eor = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_index;
    logic [11:0] out_value;
    logic        out_is_max;
    logic        out_overflow;

    int tests = 0;
    int fails = 0;
    int ready_mode = 0;   // 0: always, 1: random, 2: never
    int cycles = 0;
    logic [28:0] exp_q[$];
    string       tag_q[$];

    wave_turnpt_top dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input bit ok, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check("watchdog", 1'b0, 32'(cycles), 32'd150000);
            finish_run();
        end
    end

    // output consumer and scoreboard
    always @(negedge clk) begin
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = ($urandom % 4) != 0;
            default: out_ready = 1'b0;
        endcase
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("unexpected record", 1'b0, {3'b0, out_index, out_value, out_is_max}, 32'h0);
            end else begin
                logic [28:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {out_index, out_value, out_is_max} == e,
                      {3'b0, out_index, out_value, out_is_max}, {3'b0, e});
            end
        end
    end

    function automatic bit over(input int a, input int b, input int h);
        return (a > b) && (a - b > h);
    endfunction

    task automatic push(input int idx, input int val, input bit mx, input string tag);
        exp_q.push_back({16'(idx), 12'(val), mx});
        tag_q.push_back(tag);
    endtask

    // expected stream from the requirements
    task automatic model(input bit full, input int hy, input int s[$]);
        int trend = 0;   // 0 none, 1 up, 2 down
        int ev = 0, ei = 0;
        for (int i = 0; i < s.size(); i++) begin
            bit last = (i == s.size() - 1);
            if (full) begin
                push(i, s[i], 1'b0, "R2 full-mode sample");
            end else if (i == 0) begin
                trend = 0; ev = s[0]; ei = 0;
            end else if (last) begin
                if (trend == 1) begin
                    if (s[i] > ev) begin ev = s[i]; ei = i; end
                    push(ei, ev, 1'b1, "R8 final max");
                end else if (trend == 2) begin
                    if (s[i] < ev) begin ev = s[i]; ei = i; end
                    push(ei, ev, 1'b0, "R8 final min");
                end
            end else if (trend == 0) begin
                if (over(s[i], s[0], hy)) begin trend = 1; ev = s[i]; ei = i; end
                else if (over(s[0], s[i], hy)) begin trend = 2; ev = s[i]; ei = i; end
            end else if (trend == 1) begin
                if (s[i] > ev) begin ev = s[i]; ei = i; end
                else if (over(ev, s[i], hy)) begin
                    push(ei, ev, 1'b1, "R4 max");
                    trend = 2; ev = s[i]; ei = i;
                end
            end else begin
                if (s[i] < ev) begin ev = s[i]; ei = i; end
                else if (over(s[i], ev, hy)) begin
                    push(ei, ev, 1'b0, "R5 min");
                    trend = 1; ev = s[i]; ei = i;
                end
            end
        end
    endtask

    task automatic drive(input int v, input bit sor, input bit eor);
        @(negedge clk);
        in_valid = 1'b1; in_data = 12'(v); in_sor = sor; in_eor = eor;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
        end
    endtask

    task automatic send(input bit full, input int hy, input int s[$], input bit gaps);
        mode_full = full;
        hyst = 12'(hy);
        model(full, hy, s);
        for (int i = 0; i < s.size(); i++) begin
            if (gaps) idle($urandom % 3);
            drive(s[i], i == 0, i == s.size() - 1);
        end
        idle(1);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        idle(20);
        check(tag, exp_q.size() == 0, 32'(exp_q.size()), 32'd0);
    endtask

    function automatic void walk(ref int s[$], input int n);
        int v = 1000 + ($urandom % 2000);
        s.delete();
        for (int i = 0; i < n; i++) begin
            v = v + int'($urandom % 61) - 30;
            if (v < 0) v = 0;
            if (v > 4095) v = 4095;
            s.push_back(v);
        end
    endfunction

    initial begin
        int s[$];
        int hys[4] = '{0, 5, 25, 120};
        void'($urandom(32'd20240611));
        idle(3);
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid after reset", out_valid == 1'b0, 32'(out_valid), 32'd0);
        check("R1 overflow after reset", out_overflow == 1'b0, 32'(out_overflow), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R3: strays before any record are ignored
        mode_full = 1'b1;
        drive(11, 0, 0); drive(22, 0, 0); idle(5);
        check("R3 stray before record", out_valid == 1'b0, 32'(out_valid), 32'd0);

        // R2: full-mode ramp, then R3 strays after the end marker
        s = '{};
        for (int i = 0; i < 20; i++) s.push_back(100 + 7 * i);
        send(1'b1, 0, s, 1'b1);
        drive(33, 0, 0); drive(44, 0, 0); idle(1);
        drain("R3 nothing after end of record");

        // R4 R5 R6 R8: directed turning points, drop equal to hyst does not turn
        s = '{100, 120, 120, 110, 109, 95, 106, 106, 130};
        mode_full = 1'b0; hyst = 12'd10;
        push(1, 120, 1'b1, "R6 first index of equal peak");
        push(5, 95, 1'b0, "R5 directed min");
        push(8, 130, 1'b1, "R8 end sample extends peak");
        for (int i = 0; i < s.size(); i++) drive(s[i], i == 0, i == s.size() - 1);
        idle(1);
        drain("R4 directed stream complete");

        // R7 R8: no trend ever forms, nothing emitted
        s = '{50, 55, 45, 60, 40};
        mode_full = 1'b0; hyst = 12'd10;
        for (int i = 0; i < s.size(); i++) drive(s[i], i == 0, i == s.size() - 1);
        idle(10);
        check("R7 no trend no points", out_valid == 1'b0, 32'(out_valid), 32'd0);

        // R5: falling start, trough then rising end
        s = '{500, 480, 470, 470, 490, 485};
        push(2, 470, 1'b0, "R5 falling-first min");
        push(4, 490, 1'b1, "R8 flush after min");
        for (int i = 0; i < s.size(); i++) drive(s[i], i == 0, i == s.size() - 1);
        idle(1);
        drain("R5 falling stream complete");

        // random compressed records with stalls and gaps (R4 R5)
        ready_mode = 1;
        for (int r = 0; r < 12; r++) begin
            walk(s, 40 + ($urandom % 80));
            send(1'b0, hys[r % 4], s, 1'b1);
        end
        drain("R4 random compressed drained");
        ready_mode = 0;

        // R11: back-to-back full-mode records, one sample per clock
        for (int r = 0; r < 4; r++) begin
            walk(s, 30 + ($urandom % 40));
            mode_full = 1'b1;
            model(1'b1, 0, s);
            for (int i = 0; i < s.size(); i++) drive(s[i], i == 0, i == s.size() - 1);
        end
        idle(1);
        drain("R11 back-to-back drained");
        check("R10 no overflow in normal traffic", out_overflow == 1'b0, 32'(out_overflow), 32'd0);

        // R9 R10: stall, overflow, sticky flag
        ready_mode = 2;
        idle(2);
        mode_full = 1'b1;
        for (int i = 0; i < 20; i++) drive(300 + i, i == 0, i == 19);
        idle(5);
        check("R10 overflow set", out_overflow == 1'b1, 32'(out_overflow), 32'd1);
        for (int k = 0; k < 3; k++) begin
            check("R9 held record", out_valid && out_value == 12'd300 && out_index == 16'd0,
                  {out_valid, 3'b0, out_index, out_value}, {1'b1, 3'b0, 16'd0, 12'd300});
            idle(1);
        end
        for (int i = 0; i < 16; i++) push(i, 300 + i, 1'b0, "R10 kept entries");
        ready_mode = 0;
        drain("R10 only depth entries");
        check("R10 overflow sticky after drain", out_overflow == 1'b1, 32'(out_overflow), 32'd1);

        // R1: reset clears the flag
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check("R1 reset clears overflow", out_overflow == 1'b0, 32'(out_overflow), 32'd0);
        check("R1 reset empties output", out_valid == 1'b0, 32'(out_valid), 32'd0);
        finish_run();
    end
endmodule